// File: doc/BRIEF.md
# Adapter command and interrupt status front end

This block is the host-facing command and status port of a network adapter. The host writes one 16-bit word that carries both an operation code and its argument. It reads back, at the same location, a status word. That word holds the interrupt status bits, a command-busy flag and the number of the register window that is currently selected. Event pulses from the transmit and receive engines set status bits. The indication mask decides which events are recorded. The interrupt-enable mask decides which recorded events can drive the interrupt line. The host clears status bits with an acknowledge command whose argument names the bits to clear.

Transmit and receive resets are modelled only by their busy interval. A small state machine has the states `IDLE` and `BUSY`. Its transitions are `IDLE -> BUSY` on a reset command, `BUSY -> BUSY` on a repeated reset command (the count reloads), `BUSY -> BUSY` while the count is nonzero (the count decrements), and `BUSY -> IDLE` when the count reaches zero. The other register windows and the data paths behind them are not part of this block.

Top module: `nic_cmd_front`

## Requirements
- R1: After reset, the status word reads 0, `irq` is low and `cmd_busy` is low. The window is 0, both masks are 0 and no status bit is set.
- R2: A write with opcode 0x01 in bits 15:11 selects window `wr_data[2:0]`. The window appears in status bits 15:13 from the cycle after the write.
- R3: Event input bit k (k = 0..7) sets status bit k+1 on the next cycle only if bit k+1 of the indication mask is set. A masked event changes nothing.
- R4: Every event that passes the indication mask also sets the latch (status bit 0). This includes an event that arrives after the latch was acknowledged.
- R5: `irq` is high exactly when the latch is set and (status AND interrupt-enable AND 0x1FE) is nonzero.
- R6: Opcode 0x0D clears each status bit whose position is set in `wr_data[8:0]`, including the latch. An event that is indicated in the same cycle still sets its bit and the latch.
- R7: Opcode 0x0C sets status bit 6 and the latch when indication mask bit 6 is set.
- R8: Opcodes 0x05 and 0x0B raise `cmd_busy` and status bit 12 for exactly BUSY_CYCLES cycles after the write. Another reset command during that interval restarts the full interval.
- R9: Any other opcode changes neither the status word, `irq` nor `cmd_busy`.
- R10: Opcode 0x0E loads the interrupt-enable mask and opcode 0x0F loads the indication mask, each from `wr_data[8:0]`. Status bits 11:9 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 16 | Command word: opcode 15:11, argument 10:0 |
| evt_in | input | 8 | Event pulses for status bits 8:1 |
| rd_data | output | 16 | Status word: window 15:13, busy 12, status 8:0 |
| irq | output | 1 | Interrupt request |
| cmd_busy | output | 1 | Command in progress |

## Verification
A command write or an event pulse on one clock edge shows up in `rd_data` and `irq` on the very next edge. No register stands between the state and these outputs, so the bench compares every output at the falling edge that follows each stimulus edge. The busy flag follows a reference countdown that is loaded with BUSY_CYCLES at the command edge and drops at each later edge. The flag must therefore be high for exactly that many falling-edge samples. A reference model applies the same acknowledge-then-set order per cycle, so the expected values for simultaneous acknowledge and event cases are set before each comparison.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;

    localparam int STAT_W   = 9;
    localparam int OPC_W    = 5;
    localparam int ARG_W    = 11;
    localparam int WIN_W    = 3;
    localparam int EVT_W    = STAT_W - 1;
    localparam logic [STAT_W-1:0] INT_CAPABLE = 9'h1FE;
    localparam int REQ_BIT  = 6;

    localparam logic [OPC_W-1:0] OP_SEL_WIN = 5'h01;
    localparam logic [OPC_W-1:0] OP_RX_RST  = 5'h05;
    localparam logic [OPC_W-1:0] OP_TX_RST  = 5'h0B;
    localparam logic [OPC_W-1:0] OP_REQ_INT = 5'h0C;
    localparam logic [OPC_W-1:0] OP_ACK     = 5'h0D;
    localparam logic [OPC_W-1:0] OP_SET_IEN = 5'h0E;
    localparam logic [OPC_W-1:0] OP_SET_IND = 5'h0F;

    typedef struct packed {
        logic             sel_win;
        logic             rst_cmd;
        logic             req_int;
        logic             ack;
        logic             set_ien;
        logic             set_ind;
        logic [ARG_W-1:0] arg;
    } cmd_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } busy_state_t;

endpackage

// File: rtl/nic_cmd_decode.sv
module nic_cmd_decode
    import nic_cmd_pkg::*;
(
    input  logic                     wr_en,
    input  logic [OPC_W+ARG_W-1:0]   wr_data,
    output cmd_t                     cmd
);
    logic [OPC_W-1:0] opc;

    assign opc = wr_data[OPC_W+ARG_W-1:ARG_W];

    always_comb begin
        cmd     = '0;
        cmd.arg = wr_data[ARG_W-1:0];
        if (wr_en) begin
            unique case (opc)
                OP_SEL_WIN:           cmd.sel_win = 1'b1;
                OP_RX_RST, OP_TX_RST: cmd.rst_cmd = 1'b1;
                OP_REQ_INT:           cmd.req_int = 1'b1;
                OP_ACK:               cmd.ack     = 1'b1;
                OP_SET_IEN:           cmd.set_ien = 1'b1;
                OP_SET_IND:           cmd.set_ind = 1'b1;
                default:              ;
            endcase
        end
    end
endmodule

// File: rtl/nic_busy_fsm.sv
module nic_busy_fsm #(
    parameter int BUSY_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_cmd,
    output logic busy
);
    import nic_cmd_pkg::*;

    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_CYCLES - 1);

    busy_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rst_cmd) begin
                    state_d = ST_BUSY;
                    cnt_d   = RELOAD;
                end
            end
            ST_BUSY: begin
                if (rst_cmd) begin
                    cnt_d = RELOAD;
                end else if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == ST_BUSY);
    end

    // R8: leaving BUSY happens only once the count has run out
    p_busy_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && !rst_cmd && cnt_q != '0) |=> (state_q == ST_BUSY));
endmodule

// File: rtl/nic_int_status.sv
module nic_int_status
    import nic_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_t               cmd,
    input  logic [EVT_W-1:0]   evt_in,
    output logic [STAT_W-1:0]  stat,
    output logic               irq
);
    logic [STAT_W-1:0] ien_q, ind_q;
    logic [STAT_W-1:0] raw_set, gated_set, clr_vec;
    logic              latch_set;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
            ind_q <= '0;
        end else begin
            if (cmd.set_ien) ien_q <= cmd.arg[STAT_W-1:0];
            if (cmd.set_ind) ind_q <= cmd.arg[STAT_W-1:0];
        end
    end

    always_comb begin
        raw_set          = {evt_in, 1'b0};
        raw_set[REQ_BIT] = raw_set[REQ_BIT] | cmd.req_int;
        gated_set        = raw_set & ind_q & INT_CAPABLE;
        latch_set        = |gated_set;
        clr_vec          = cmd.ack ? cmd.arg[STAT_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               stat[0] <= 1'b0;
        else if (latch_set)       stat[0] <= 1'b1;
        else if (clr_vec[0])      stat[0] <= 1'b0;
    end

    for (genvar k = 1; k < STAT_W; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)            stat[k] <= 1'b0;
            else if (gated_set[k]) stat[k] <= 1'b1;
            else if (clr_vec[k])   stat[k] <= 1'b0;
        end
    end

    always_comb begin
        irq = stat[0] && |(stat & ien_q & INT_CAPABLE);
    end

    // R6: a pure acknowledge leaves none of its named bits set
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.ack && evt_in == '0) |=> ((stat & $past(cmd.arg[STAT_W-1:0])) == '0));

    // R4: an indicated event always leaves the latch set
    p_latch_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|({evt_in, 1'b0} & ind_q)) |=> stat[0]);

    // R3: a bit that nothing indicated stays clear
    p_masked_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat[1] && !ind_q[1]) |=> !stat[1]);
endmodule

// File: rtl/nic_cmd_front.sv
module nic_cmd_front #(
    parameter int BUSY_CYCLES = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic [7:0]  evt_in,
    output logic [15:0] rd_data,
    output logic        irq,
    output logic        cmd_busy
);
    import nic_cmd_pkg::*;

    cmd_t               cmd;
    logic [WIN_W-1:0]   win_q;
    logic [STAT_W-1:0]  stat;

    nic_cmd_decode u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    nic_busy_fsm #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_cmd (cmd.rst_cmd),
        .busy    (cmd_busy)
    );

    nic_int_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .evt_in (evt_in),
        .stat   (stat),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)           win_q <= '0;
        else if (cmd.sel_win) win_q <= cmd.arg[WIN_W-1:0];
    end

    assign rd_data = {win_q, cmd_busy, 3'b000, stat};

    // R2: window selection is visible one cycle after the command
    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[15:11] == 5'h01) |=> (rd_data[15:13] == $past(wr_data[2:0])));

    // R8: busy only ever starts from a reset command
    p_busy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_busy) |-> $past(wr_en && (wr_data[15:11] == 5'h05 || wr_data[15:11] == 5'h0B)));

    // R5: the interrupt line needs the latch
    p_irq_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rd_data[0]);
endmodule

// File: tb/nic_cmd_front_tb.sv
module nic_cmd_front_tb;
    localparam int NB = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  evt_in = '0;
    logic [15:0] rd_data;
    logic        irq;
    logic        cmd_busy;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [2:0] mwin;
    logic [8:0] mstat, mien, mind;
    int         mcnt;

    always #10 clk = ~clk;

    nic_cmd_front #(.BUSY_CYCLES(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .evt_in(evt_in), .rd_data(rd_data), .irq(irq), .cmd_busy(cmd_busy)
    );

    function automatic logic [15:0] exp_rd();
        return {mwin, (mcnt != 0), 3'b000, mstat};
    endfunction

    function automatic logic exp_irq();
        return mstat[0] && |(mstat & mien & 9'h1FE);
    endfunction

    task automatic model_step(input logic w, input logic [15:0] d, input logic [7:0] e);
        logic [4:0] op;
        logic [8:0] setv, clrv;
        op   = d[15:11];
        setv = {e, 1'b0};
        clrv = '0;
        if (mcnt > 0) mcnt--;
        if (w) begin
            case (op)
                5'h01: mwin = d[2:0];
                5'h05, 5'h0B: mcnt = NB;
                5'h0C: setv[6] = 1'b1;
                5'h0D: clrv = d[8:0];
                default: ;
            endcase
        end
        setv  = setv & mind & 9'h1FE;
        mstat = (mstat & ~clrv) | setv | {8'b0, |setv};
        if (w && op == 5'h0E) mien = d[8:0];
        if (w && op == 5'h0F) mind = d[8:0];
    endtask

    task automatic compare(input string tag);
        vectors++;
        if (rd_data !== exp_rd() || irq !== exp_irq() || cmd_busy !== (mcnt != 0)) begin
            fails++;
            $display("FAIL %s: rd=%h irq=%b busy=%b expected rd=%h irq=%b busy=%b",
                     tag, rd_data, irq, cmd_busy, exp_rd(), exp_irq(), (mcnt != 0));
        end
    endtask

    task automatic cyc(input logic w, input logic [15:0] d, input logic [7:0] e, input string tag);
        wr_en = w; wr_data = d; evt_in = e;
        @(posedge clk);
        model_step(w, d, e);
        @(negedge clk);
        wr_en = 1'b0; evt_in = '0;
        compare(tag);
    endtask

    function automatic logic [15:0] cw(input logic [4:0] op, input logic [10:0] a);
        return {op, a};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        mwin = '0; mstat = '0; mien = '0; mind = '0; mcnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 reset state");

        cyc(1, cw(5'h01, 11'd5), 8'h00, "R2 select window 5");
        cyc(1, cw(5'h01, 11'h7FA), 8'h00, "R2 select window 2 upper arg ignored");
        cyc(0, '0, 8'hFF, "R3 events with indication mask clear");
        cyc(1, cw(5'h0F, 11'h1FE), 8'h00, "R10 load indication mask");
        cyc(0, '0, 8'h02, "R4 tx complete sets bit 2 and latch");
        cyc(1, cw(5'h0E, 11'h004), 8'h00, "R5 enable bit 2 raises irq");
        cyc(1, cw(5'h0D, 11'h001), 8'h00, "R6 ack latch only drops irq");
        cyc(0, '0, 8'h02, "R4 event after ack relatches");
        cyc(1, cw(5'h0D, 11'h005), 8'h02, "R6 ack and event same cycle");
        cyc(1, cw(5'h0D, 11'h1FF), 8'h00, "R6 ack all bits");
        cyc(1, cw(5'h0C, 11'h000), 8'h00, "R7 request interrupt");
        cyc(1, cw(5'h1F, 11'h7FF), 8'h00, "R9 unknown opcode 0x1F");
        cyc(1, cw(5'h00, 11'h1FF), 8'h00, "R9 unknown opcode 0x00");
        cyc(1, cw(5'h0F, 11'h004), 8'h00, "R10 narrow indication mask");
        cyc(0, '0, 8'h01, "R3 masked host error ignored");
        cyc(1, cw(5'h05, 11'h000), 8'h00, "R8 receive reset busy");
        for (int i = 0; i < 3; i++) cyc(0, '0, 8'h00, "R8 busy hold");
        cyc(1, cw(5'h0B, 11'h7FF), 8'h00, "R8 transmit reset restarts");
        for (int i = 0; i < NB + 2; i++) cyc(0, '0, 8'h00, "R8 busy countdown");

        for (int i = 0; i < 4000; i++) begin
            logic [4:0]  op;
            logic [15:0] d;
            logic [7:0]  e;
            logic        w;
            case ($urandom_range(0, 9))
                0: op = 5'h01;
                1: op = 5'h05;
                2: op = 5'h0B;
                3: op = 5'h0C;
                4, 5: op = 5'h0D;
                6: op = 5'h0E;
                7: op = 5'h0F;
                default: op = 5'($urandom);
            endcase
            d = {op, 11'($urandom)};
            w = ($urandom_range(0, 2) == 0);
            e = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            cyc(w, d, e, "R5 R6 random mix");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule